// File: doc/BRIEF.md
# Converter Clock Prescaler with Time-Base Ticks

This block turns the bus clock into three clock enables for an analog-to-digital converter subsystem. The first is a converter clock enable. It is high for one bus cycle out of every N, where N is the main division factor. The second and third are tick pulses. Each one counts converter clock periods, not bus cycles, and the slower logic around the converter uses them as time bases for settle waits and timeouts. In a typical setup one tick marks 10 µs and the other marks 1 ms. All outputs are enables in the bus clock domain. No derived clock is generated.

One 32-bit configuration word sets all three ratios. Software computes each factor from the bus clock frequency and writes the factor minus one into its field. Any write to the word restarts every counter from zero, so the new ratios apply from the next cycle.

A parameter selects a reduced layout. In that layout the main factor is limited to 64, the tick field moves to a higher position and the millisecond tick is absent.

Top module: `adc_clk_prescaler`

## Requirements
- R1: While rst_n is low, conv_en, tick_10us and tick_1ms are all low. Reset clears all three fields to zero.
- R2: In the standard layout, main divide value M sits in cfg_wdata[7:0]. After a write, conv_en is high in bus cycle n (counting n = 0 from the first cycle after the write edge) exactly when n mod (M+1) equals M.
- R3: A main field of zero gives conv_en high in every cycle after reset release or after a write.
- R4: In the standard layout, tick divide value T sits in cfg_wdata[15:8]. tick_10us is high only in conv_en cycles. It fires on the k-th conv_en pulse (k = 0 first) exactly when k mod (T+1) equals T.
- R5: In the standard layout, millisecond divide value S sits in cfg_wdata[23:16]. It counts conv_en pulses independently of the other tick. tick_1ms fires on the k-th pulse exactly when k mod (S+1) equals S.
- R6: A write clears all counters, including one made in the middle of a count. Timing after the write follows R2 to R5 with the new values, from n = 0.
- R7: cfg_wdata[31:24] has no effect on any output.
- R8: With ALT_LAYOUT = 1, the main value is cfg_wdata[5:0] (factor 1 to 64) and the tick value is cfg_wdata[23:16]. tick_1ms stays low. Bits [15:6] and [31:24] are ignored.
- R9: Neither tick is ever high in a cycle where conv_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the divider word |
| cfg_wdata | input | 32 | Divider word; each field holds factor minus one |
| conv_en | output | 1 | Converter clock enable |
| tick_10us | output | 1 | Short time-base tick, aligned with conv_en |
| tick_1ms | output | 1 | Long time-base tick, aligned with conv_en |

## Verification
Two events can fall in the same cycle. A write can arrive in a cycle where a conv_en pulse or a tick is due. The two ticks can also both fire on the same converter pulse. The bench writes new words at arbitrary points in the middle of a count, and it picks ratios whose common multiples bring both ticks onto one pulse. Each cycle after a write is judged against the pulse schedule of the new word, counted from zero. No step from the old count may carry over.

// File: rtl/adc_pre_pkg.sv
package adc_pre_pkg;
   localparam int CFG_W       = 32;
   localparam int FIELD_W     = 8;
   localparam int MAIN_LSB    = 0;
   localparam int T10_LSB_STD = 8;
   localparam int T10_LSB_ALT = 16;
   localparam int MS_LSB      = 16;
   localparam int MAIN_W_STD  = 8;
   localparam int MAIN_W_ALT  = 6;

   function automatic int main_width(input bit alt);
      return alt ? MAIN_W_ALT : MAIN_W_STD;
   endfunction

   function automatic int t10_lsb(input bit alt);
      return alt ? T10_LSB_ALT : T10_LSB_STD;
   endfunction
endpackage

// File: rtl/adc_pre_div.sv
module adc_pre_div #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   input  logic         step,
   input  logic [W-1:0] limit,
   output logic         hit
);
   logic [W-1:0] cnt;

   assign hit = step && (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (restart) cnt <= '0;
      else if (step)    cnt <= hit ? '0 : cnt + 1'b1;
   end

   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= limit);
   p_restart_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt == '0));
   p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !restart) |=> (cnt == '0));
endmodule

// File: rtl/adc_pre_cfg.sv
module adc_pre_cfg
   import adc_pre_pkg::*;
#(
   parameter bit ALT    = 1'b0,
   parameter int MAIN_W = 8,
   parameter int TICK_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [CFG_W-1:0]  wdata,
   output logic [MAIN_W-1:0] main_lim,
   output logic [TICK_W-1:0] t10_lim,
   output logic [TICK_W-1:0] ms_lim
);
   localparam int T10_LSB = t10_lsb(ALT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         main_lim <= '0;
         t10_lim  <= '0;
      end else if (we) begin
         main_lim <= wdata[MAIN_LSB +: MAIN_W];
         t10_lim  <= wdata[T10_LSB +: TICK_W];
      end
   end

   generate
      if (ALT) begin : g_no_ms
         assign ms_lim = '0;
      end else begin : g_ms
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  ms_lim <= '0;
            else if (we) ms_lim <= wdata[MS_LSB +: TICK_W];
         end
      end
   endgenerate

   p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (main_lim == $past(wdata[MAIN_LSB +: MAIN_W])));
endmodule

// File: rtl/adc_clk_prescaler.sv
module adc_clk_prescaler
   import adc_pre_pkg::*;
#(
   parameter bit ALT_LAYOUT = 1'b0,
   parameter int TICK_W     = FIELD_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic             conv_en,
   output logic             tick_10us,
   output logic             tick_1ms
);
   localparam int MAIN_W = main_width(ALT_LAYOUT);

   generate
      if (MAIN_W > FIELD_W || TICK_W > FIELD_W) begin : g_bad_width
         $error("divider field wider than its slot");
      end
   endgenerate

   logic              run;
   logic [MAIN_W-1:0] main_lim;
   logic [TICK_W-1:0] t10_lim;
   logic [TICK_W-1:0] ms_lim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run <= 1'b0;
      else        run <= 1'b1;
   end

   adc_pre_cfg #(.ALT(ALT_LAYOUT), .MAIN_W(MAIN_W), .TICK_W(TICK_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
      .main_lim(main_lim), .t10_lim(t10_lim), .ms_lim(ms_lim));

   adc_pre_div #(.W(MAIN_W)) u_main (
      .clk(clk), .rst_n(rst_n), .restart(cfg_we), .step(run),
      .limit(main_lim), .hit(conv_en));

   adc_pre_div #(.W(TICK_W)) u_t10 (
      .clk(clk), .rst_n(rst_n), .restart(cfg_we), .step(conv_en),
      .limit(t10_lim), .hit(tick_10us));

   generate
      if (ALT_LAYOUT) begin : g_alt
         logic ms_unused;
         assign ms_unused = |ms_lim;
         assign tick_1ms  = 1'b0 & ms_unused;
         p_no_ms_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !tick_1ms);
      end else begin : g_std
         adc_pre_div #(.W(TICK_W)) u_ms (
            .clk(clk), .rst_n(rst_n), .restart(cfg_we), .step(conv_en),
            .limit(ms_lim), .hit(tick_1ms));
         p_ms_in_conv_r5: assert property (@(posedge clk) disable iff (!rst_n)
            tick_1ms |-> conv_en);
      end
   endgenerate

   p_tick_in_conv_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tick_10us |-> conv_en);
   p_zero_every_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && main_lim == '0) |-> conv_en);
endmodule

// File: tb/adc_clk_prescaler_test.sv
`timescale 1ns/1ps
module adc_clk_prescaler_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   logic conv_s, t10_s, ms_s, conv_a, t10_a, ms_a;
   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   adc_clk_prescaler #(.ALT_LAYOUT(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(we), .cfg_wdata(wdata),
      .conv_en(conv_s), .tick_10us(t10_s), .tick_1ms(ms_s));

   adc_clk_prescaler #(.ALT_LAYOUT(1'b1)) uut_alt (
      .clk(clk), .rst_n(rst_n), .cfg_we(we), .cfg_wdata(wdata),
      .conv_en(conv_a), .tick_10us(t10_a), .tick_1ms(ms_a));

   function automatic bit exp_conv(input int n, input int m);
      return (n % (m + 1)) == m;
   endfunction

   function automatic bit exp_tick(input int n, input int m, input int t);
      return exp_conv(n, m) && (((n / (m + 1)) % (t + 1)) == t);
   endfunction

   task automatic chk(input string req, input logic act, input logic exp, input int n);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s cycle %0d: actual=%b expected=%b", req, n, act, exp);
      end
   endtask

   task automatic wr(input logic [31:0] d);
      @(negedge clk);
      we = 1'b1; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   // Checks cycles 0..len-1 after the last write (or reset release) for both layouts.
   task automatic run(input logic [31:0] d, input int len);
      int m  = int'(d[7:0]);
      int t  = int'(d[15:8]);
      int s  = int'(d[23:16]);
      int ma = int'(d[5:0]);
      int ta = int'(d[23:16]);
      for (int n = 0; n < len; n++) begin
         chk("R2/R3 conv_en", conv_s, exp_conv(n, m), n);
         chk("R4 tick_10us", t10_s, exp_tick(n, m, t), n);
         chk("R5 tick_1ms", ms_s, exp_tick(n, m, s), n);
         chk("R8 alt conv_en", conv_a, exp_conv(n, ma), n);
         chk("R8 alt tick_10us", t10_a, exp_tick(n, ma, ta), n);
         chk("R8 alt tick_1ms", ms_a, 1'b0, n);
         @(negedge clk);
      end
   endtask

   initial begin
      void'($urandom(32'd1357));
      // R1: outputs quiet in reset
      repeat (3) @(negedge clk);
      chk("R1 conv_en in reset", conv_s, 1'b0, -1);
      chk("R1 tick_10us in reset", t10_s, 1'b0, -1);
      chk("R1 tick_1ms in reset", ms_s, 1'b0, -1);
      chk("R1 alt conv_en in reset", conv_a, 1'b0, -1);
      rst_n = 1'b1;
      @(negedge clk);
      // R1/R3: cleared fields give an enable in every cycle
      run(32'h0, 20);
      // R3: explicit zero write, garbage in ignored bits (R7)
      wr(32'hA5_00_00_00);
      run(32'hA5_00_00_00, 30);
      // Directed: large main factor, ticks on the second and third pulses
      wr(32'h3C_02_01_FF);
      run(32'h3C_02_01_FF, 1600);
      // R4/R5 coincidence: T=1, S=3 share pulses
      wr(32'h00_03_01_02);
      run(32'h00_03_01_02, 200);
      // R6: write in mid-count, then new ratio from zero
      wr(32'h00_04_02_06);
      run(32'h00_04_02_06, 23);
      wr(32'h7E_01_03_01);
      run(32'h7E_01_03_01, 150);
      // Random configurations; upper byte random to cover R7
      for (int i = 0; i < 24; i++) begin
         logic [31:0] d;
         d[7:0]   = 8'($urandom % 7);
         d[15:8]  = 8'($urandom % 6);
         d[23:16] = 8'($urandom % 9);
         d[31:24] = 8'($urandom);
         if (i % 5 == 4) d[7:6] = 2'b11;  // R8 ignores bits 7:6
         wr(d);
         run(d, 37 + int'($urandom % 300));
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1_500_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule